// File: doc/BRIEF.md
# Time-Shared Matrix Multiply-Accumulate Engine

This block adds the product of two square signed fixed-point matrices into a third: C ← C + A×B, all N×N. The arithmetic runs on N/II multiply-add lanes. II is a compile-time sharing factor that must divide N, and each lane serves II columns of a row in turn. A larger II means fewer lanes, more cycles and deeper banks. II = 1 gives one lane per column. II = N gives a single lane.

A host loads A, B and the starting C through a write port while the engine is idle. It pulses `start` and waits for the one-cycle `done` pulse. It then reads C back through a registered read port. The loop order puts the inner-product index k outermost, then the row i, then the column group g. In each issue cycle, every lane j updates element C[i][g·L + j], where L = N/II. The engine reads A[i][k] once per row, holds it, and broadcasts it to every lane. B and C are split column-interleaved into L banks: column c lives in lane c mod L at slot c div L. One shared address generator drives every bank with the same local address. Each logical bank is built from physical blocks of PD words, and only the addressed block is enabled on any cycle.

The control is a three-state machine:
- IDLE to RUN when `start` is high.
- RUN to DRAIN when the final (k, i, g) triple issues.
- DRAIN to IDLE when that triple's C write retires, which is also the cycle `done` is raised.

The lane pipeline has four stages: issue/B read, operand registers, product register, then C read-add into the output register, followed by the write-back.

Top module: `mm_engine`

## Requirements
- R1: After reset `busy` and `done` are low.
- R2: After an operation each C[i][j] equals its prior value plus the sum over k of A[i][k]·B[k][j]. A and B are DW-bit signed, and C wraps at AW bits, signed.
- R3: `done` is high for exactly one cycle, N²·II+3 rising edges after the edge that accepted `start`. `busy` falls on that same edge.
- R4: `busy` rises on the edge that accepts `start` and stays high until R3's edge. A `start` seen while busy is ignored and changes neither timing nor results.
- R5: Host writes use `wr_sel` 0 = A, 1 = B, 2 = C (sign-extended), 3 = no write, at element (`wr_row`, `wr_col`). Writes while `busy` is high are ignored.
- R6: `rd_data` holds C[`rd_row`][`rd_col`] one cycle after the address is presented while idle.
- R7: Repeated operations accumulate onto C. The results are identical for II = 1, II = N and any divisor between.
- R8: In each bank at most one physical block is read-enabled and at most one is write-enabled per cycle.
- R9: A C read in the pipeline never targets the address being written back on the same cycle (requires N·II ≥ 2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 2 | Target matrix: 0 A, 1 B, 2 C, 3 none |
| wr_row | input | clog2(N) | Host write row |
| wr_col | input | clog2(N) | Host write column |
| wr_data | input | DW | Host write value, signed |
| rd_row | input | clog2(N) | Host read row of C |
| rd_col | input | clog2(N) | Host read column of C |
| rd_data | output | AW | Registered C element |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume two things about the host. It raises `start` and uses the write and read ports only as R4–R6 allow. It also picks N·II of at least two and a power-of-two PD, because the hazard property (R9) and the block decode (R8) depend on both.

The stimulus keeps within these limits in three ways:
- It builds three copies of the engine with N = 4 and II = 1, 2 and 4.
- It loads all memories only while idle.
- It deliberately drives a second `start`, a C write and an A write mid-operation, and expects them to have no effect.

Operand values, including the most negative and most positive, are chosen so that no sum leaves the AW-bit range.

// File: rtl/mm_pkg.sv
`timescale 1ns/1ps
package mm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } mm_state_e;

    typedef enum logic [1:0] {
        SEL_A    = 2'd0,
        SEL_B    = 2'd1,
        SEL_C    = 2'd2,
        SEL_NONE = 2'd3
    } host_sel_e;

    function automatic int width_of(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/mm_bank.sv
`timescale 1ns/1ps
module mm_bank import mm_pkg::*; #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    parameter int PD    = 4,
    localparam int AB   = width_of(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_en,
    input  logic [AB-1:0] rd_addr,
    output logic [W-1:0] rd_data,
    input  logic         wr_en,
    input  logic [AB-1:0] wr_addr,
    input  logic [W-1:0] wr_data
);
    localparam int PW = width_of(PD);
    localparam int NB = (DEPTH + PD - 1) / PD;

    logic [NB-1:0] blk_rd;
    logic [NB-1:0] blk_wr;
    logic [W-1:0]  blk_q [NB];
    logic [PW-1:0] rd_off;
    logic [PW-1:0] wr_off;
    int            rd_blk;
    int            wr_blk;

    always_comb begin
        rd_blk = int'(rd_addr) / PD;
        wr_blk = int'(wr_addr) / PD;
        rd_off = PW'(int'(rd_addr) % PD);
        wr_off = PW'(int'(wr_addr) % PD);
    end

    for (genvar b = 0; b < NB; b++) begin : g_blk
        logic [W-1:0] mem [PD];
        assign blk_rd[b] = rd_en && (rd_blk == b);
        assign blk_wr[b] = wr_en && (wr_blk == b);
        always_ff @(posedge clk) begin
            if (blk_wr[b]) mem[wr_off] <= wr_data;
        end
        assign blk_q[b] = blk_rd[b] ? mem[rd_off] : '0;
    end

    always_comb begin
        rd_data = '0;
        for (int b = 0; b < NB; b++) rd_data = rd_data | blk_q[b];
    end

    // R8: one physical block at a time per port
    p_one_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(blk_rd) && $onehot0(blk_wr));
endmodule

// File: rtl/mm_addr_gen.sv
`timescale 1ns/1ps
module mm_addr_gen import mm_pkg::*; #(
    parameter int N  = 4,
    parameter int II = 2,
    localparam int RW = width_of(N),
    localparam int GW = width_of(II)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    output logic [RW-1:0] k_idx,
    output logic [RW-1:0] i_idx,
    output logic [GW-1:0] g_idx,
    output logic          last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k_idx <= '0;
            i_idx <= '0;
            g_idx <= '0;
        end else if (clr) begin
            k_idx <= '0;
            i_idx <= '0;
            g_idx <= '0;
        end else if (adv) begin
            if (g_idx == GW'(II - 1)) begin
                g_idx <= '0;
                if (i_idx == RW'(N - 1)) begin
                    i_idx <= '0;
                    k_idx <= (k_idx == RW'(N - 1)) ? '0 : k_idx + RW'(1);
                end else begin
                    i_idx <= i_idx + RW'(1);
                end
            end else begin
                g_idx <= g_idx + GW'(1);
            end
        end
    end

    assign last = (k_idx == RW'(N - 1)) && (i_idx == RW'(N - 1)) && (g_idx == GW'(II - 1));
endmodule

// File: rtl/mm_lane.sv
`timescale 1ns/1ps
module mm_lane import mm_pkg::*; #(
    parameter int N   = 4,
    parameter int II  = 2,
    parameter int DW  = 8,
    parameter int AW  = 24,
    parameter int PD  = 4,
    localparam int BAW = width_of(N * II)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 busy,
    input  logic                 iss_v,
    input  logic [BAW-1:0]       b_addr,
    input  logic [BAW-1:0]       c_addr,
    input  logic signed [DW-1:0] a_val,
    input  logic                 hb_we,
    input  logic                 hc_we,
    input  logic [BAW-1:0]       h_wr_addr,
    input  logic signed [DW-1:0] h_wr_data,
    input  logic [BAW-1:0]       h_rd_addr,
    output logic [AW-1:0]        h_rd_data
);
    localparam int DEPTH = N * II;

    logic [DW-1:0]        b_q;
    logic [AW-1:0]        c_q;
    logic signed [DW-1:0] b_in;
    logic signed [AW-1:0] a_ext;
    logic signed [AW-1:0] b_ext;
    logic signed [AW-1:0] prod;
    logic [AW-1:0]        out_r;
    logic                 v1, v2, v3;
    logic [BAW-1:0]       ca1, ca2, ca3;
    logic                 c_rd_en, c_wr_en;
    logic [BAW-1:0]       c_rd_addr, c_wr_addr;
    logic [AW-1:0]        c_wr_data;

    mm_bank #(.DEPTH(DEPTH), .W(DW), .PD(PD)) u_bbank (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (iss_v),
        .rd_addr (b_addr),
        .rd_data (b_q),
        .wr_en   (hb_we),
        .wr_addr (h_wr_addr),
        .wr_data (h_wr_data)
    );

    always_comb begin
        c_rd_en   = busy ? v2 : 1'b1;
        c_rd_addr = busy ? ca2 : h_rd_addr;
        c_wr_en   = busy ? v3 : hc_we;
        c_wr_addr = busy ? ca3 : h_wr_addr;
        c_wr_data = busy ? out_r : AW'(h_wr_data);
    end

    mm_bank #(.DEPTH(DEPTH), .W(AW), .PD(PD)) u_cbank (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (c_rd_en),
        .rd_addr (c_rd_addr),
        .rd_data (c_q),
        .wr_en   (c_wr_en),
        .wr_addr (c_wr_addr),
        .wr_data (c_wr_data)
    );

    assign a_ext     = AW'(a_val);
    assign b_ext     = AW'(b_in);
    assign h_rd_data = c_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
            ca1 <= '0; ca2 <= '0; ca3 <= '0;
            b_in <= '0; prod <= '0; out_r <= '0;
        end else begin
            v1    <= iss_v;
            v2    <= v1;
            v3    <= v2;
            ca1   <= c_addr;
            ca2   <= ca1;
            ca3   <= ca2;
            b_in  <= b_q;
            prod  <= a_ext * b_ext;
            out_r <= c_q + prod;
        end
    end

    // R9: read-add never overlaps the pending write-back address
    p_no_rmw_hazard_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (v2 && v3) |-> (ca2 != ca3));
endmodule

// File: rtl/mm_engine.sv
`timescale 1ns/1ps
module mm_engine import mm_pkg::*; #(
    parameter int N  = 4,
    parameter int II = 2,
    parameter int DW = 8,
    parameter int AW = 24,
    parameter int PD = 4,
    localparam int RW = width_of(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [RW-1:0] wr_row,
    input  logic [RW-1:0] wr_col,
    input  logic [DW-1:0] wr_data,
    input  logic [RW-1:0] rd_row,
    input  logic [RW-1:0] rd_col,
    output logic [AW-1:0] rd_data,
    output logic          busy,
    output logic          done
);
    localparam int L     = N / II;
    localparam int GW    = width_of(II);
    localparam int BAW   = width_of(N * II);
    localparam int AIW   = width_of(N * N);
    localparam int TOTAL = N * N * II;

    mm_state_e            state, nxt;
    logic                 iss_v, gen_last, host_ok;
    logic                 lst1, lst2, lst3;
    logic [RW-1:0]        k_idx, i_idx;
    logic [GW-1:0]        g_idx;
    logic [BAW-1:0]       b_addr, c_addr, h_wr_addr, h_rd_addr;
    int                   h_lane, r_lane;
    logic signed [DW-1:0] amem [N*N];
    logic signed [DW-1:0] a_hold;
    logic [AW-1:0]        lane_rd [L];
    logic [AW-1:0]        rd_pick;
    int                   iss_cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start)    nxt = ST_RUN;
            ST_RUN:   if (gen_last) nxt = ST_DRAIN;
            ST_DRAIN: if (lst3)     nxt = ST_IDLE;
            default:                nxt = ST_IDLE;
        endcase
    end

    assign busy    = (state != ST_IDLE);
    assign iss_v   = (state == ST_RUN);
    assign host_ok = wr_en && !busy;

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done    <= 1'b0;
            rd_data <= '0;
        end else begin
            done    <= lst3;
            rd_data <= rd_pick;
        end
    end

    mm_addr_gen #(.N(N), .II(II)) u_agen (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state == ST_IDLE),
        .adv   (iss_v),
        .k_idx (k_idx),
        .i_idx (i_idx),
        .g_idx (g_idx),
        .last  (gen_last)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lst1 <= 1'b0; lst2 <= 1'b0; lst3 <= 1'b0;
        end else begin
            lst1 <= iss_v && gen_last;
            lst2 <= lst1;
            lst3 <= lst2;
        end
    end

    // A store and row-held broadcast operand
    always_ff @(posedge clk) begin
        if (host_ok && wr_sel == SEL_A)
            amem[AIW'(int'(wr_row) * N + int'(wr_col))] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      a_hold <= '0;
        else if (iss_v && g_idx == '0)   a_hold <= amem[AIW'(int'(i_idx) * N + int'(k_idx))];
    end

    // shared local addresses
    always_comb begin
        b_addr    = BAW'(int'(k_idx) * II + int'(g_idx));
        c_addr    = BAW'(int'(i_idx) * II + int'(g_idx));
        h_wr_addr = BAW'(int'(wr_row) * II + int'(wr_col) / L);
        h_rd_addr = BAW'(int'(rd_row) * II + int'(rd_col) / L);
        h_lane    = int'(wr_col) % L;
        r_lane    = int'(rd_col) % L;
    end

    for (genvar j = 0; j < L; j++) begin : g_lane
        mm_lane #(.N(N), .II(II), .DW(DW), .AW(AW), .PD(PD)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .busy      (busy),
            .iss_v     (iss_v),
            .b_addr    (b_addr),
            .c_addr    (c_addr),
            .a_val     (a_hold),
            .hb_we     (host_ok && wr_sel == SEL_B && h_lane == j),
            .hc_we     (host_ok && wr_sel == SEL_C && h_lane == j),
            .h_wr_addr (h_wr_addr),
            .h_wr_data (wr_data),
            .h_rd_addr (h_rd_addr),
            .h_rd_data (lane_rd[j])
        );
    end

    always_comb begin
        rd_pick = '0;
        for (int j = 0; j < L; j++) if (r_lane == j) rd_pick = lane_rd[j];
    end

    // issue counter used only by the assertion below
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 iss_cnt <= 0;
        else if (state == ST_IDLE)  iss_cnt <= 0;
        else if (iss_v)             iss_cnt <= iss_cnt + 1;
    end

    p_issue_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_v && gen_last) |-> (iss_cnt == TOTAL - 1));
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_ends_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    p_start_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_v && start) |=> busy);
endmodule

// File: tb/tb_mm_engine.sv
`timescale 1ns/1ps
module tb_mm_engine;
    localparam int N = 4, DW = 8, AW = 24, PD = 4;
    localparam int ND = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd3;
    logic [1:0] wr_row = '0, wr_col = '0, rd_row = '0, rd_col = '0;
    logic [DW-1:0] wr_data = '0;
    logic [ND-1:0] busy_v, done_v;
    logic [AW-1:0] rdq [ND];

    int ra [N][N];
    int rb [N][N];
    int rc [N][N];
    int tot [ND] = '{N*N*2+3, N*N*1+3, N*N*4+3};
    int n_chk = 0, n_err = 0;

    always #2 clk = ~clk;

    mm_engine #(.N(N), .II(2), .DW(DW), .AW(AW), .PD(PD)) dut (
        .clk, .rst_n, .start, .wr_en, .wr_sel, .wr_row, .wr_col, .wr_data,
        .rd_row, .rd_col, .rd_data(rdq[0]), .busy(busy_v[0]), .done(done_v[0]));
    mm_engine #(.N(N), .II(1), .DW(DW), .AW(AW), .PD(PD)) dut_ii1 (
        .clk, .rst_n, .start, .wr_en, .wr_sel, .wr_row, .wr_col, .wr_data,
        .rd_row, .rd_col, .rd_data(rdq[1]), .busy(busy_v[1]), .done(done_v[1]));
    mm_engine #(.N(N), .II(N), .DW(DW), .AW(AW), .PD(PD)) dut_iin (
        .clk, .rst_n, .start, .wr_en, .wr_sel, .wr_row, .wr_col, .wr_data,
        .rd_row, .rd_col, .rd_data(rdq[2]), .busy(busy_v[2]), .done(done_v[2]));

    function automatic void chk(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endfunction

    function automatic int rnd8();
        logic [7:0] t = 8'($urandom);
        return int'($signed(t));
    endfunction

    task automatic host_wr(input logic [1:0] s, input int r, input int c, input int d);
        wr_en = 1'b1; wr_sel = s; wr_row = 2'(r); wr_col = 2'(c); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd3;
    endtask

    // R5: sel 0 A, 1 B, 2 C
    task automatic load(input int mode);
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
                int a = (mode == 0) ? rnd8() : ((r + c) % 2 == 0 ? -128 : 127);
                int b = (mode == 0) ? rnd8() : -128;
                ra[r][c] = a; rb[r][c] = b;
                host_wr(2'd0, r, c, a);
                host_wr(2'd1, r, c, b);
                if (mode == 0) begin
                    rc[r][c] = rnd8();
                    host_wr(2'd2, r, c, rc[r][c]);
                end
            end
    endtask

    // R3/R4 timing tracked every clock; disturbances test R4 and R5 while busy
    task automatic run_op(input bit disturb);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int m = 0; m < 72; m++) begin
            for (int d = 0; d < ND; d++) begin
                chk("R4 busy", int'(busy_v[d]), int'(m < tot[d]));
                chk("R3 done", int'(done_v[d]), int'(m == tot[d]));
            end
            if (disturb && m == 3) begin
                start = 1'b1; wr_en = 1'b1; wr_sel = 2'd2;
                wr_row = 2'd0; wr_col = 2'd0; wr_data = 8'd55;
            end else if (disturb && m == 5) begin
                start = 1'b0; wr_en = 1'b1; wr_sel = 2'd0;
                wr_row = 2'd1; wr_col = 2'd2; wr_data = 8'd77;
            end else begin
                start = 1'b0; wr_en = 1'b0; wr_sel = 2'd3;
            end
            @(negedge clk);
        end
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                for (int k = 0; k < N; k++) rc[i][j] += ra[i][k] * rb[k][j];
    endtask

    // R6: registered read, one cycle latency
    task automatic readback(input string req);
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
                rd_row = 2'(r); rd_col = 2'(c);
                @(negedge clk);
                for (int d = 0; d < ND; d++) chk(req, int'($signed(rdq[d])), rc[r][c]);
            end
    endtask

    initial begin
        #400000;
        n_err++;
        $display("FAIL R4 watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        for (int d = 0; d < ND; d++) begin
            chk("R1 busy", int'(busy_v[d]), 0);
            chk("R1 done", int'(done_v[d]), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        load(0);
        readback("R6 C preload");
        run_op(1'b1);
        readback("R2 R5 R7 random");
        load(1);
        host_wr(2'd3, 0, 1, 99);   // R5 sel 3 writes nothing
        run_op(1'b0);
        readback("R2 R7 extremes");
        // R8 R9 are guarded by the assertions inside the RTL
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule